// File: doc/BRIEF.md
# Zero-Suppressing Hit Packet Builder

On each trigger strobe, this block captures one digitized front-end frame of 128 channels, each holding a 6-bit amplitude. Along with the frame it captures the threshold, the chip address and the bunch-crossing count present at the strobe. It then emits one packet of words on a valid/ready stream. The first word of every packet is a header that identifies the chip and the crossing. After the header comes one record for each channel whose amplitude lies above the threshold, so packet length follows occupancy. A flag marks the final word of each packet.

Triggers are captured into a small queue. A trigger that arrives while a packet is still draining therefore waits its turn instead of being lost. If the queue is full, the trigger is dropped and a sticky overflow flag reports that at least one packet is missing.

Top module: `hit_packet_builder`

## Requirements
- R1: The first word of every packet is the header, laid out as chip address in bits [19:12] and timestamp in bits [11:0]. Both values are the ones present on the inputs in the cycle the trigger was sampled, and later changes to those inputs do not affect them.
- R2: Each hit word carries the channel address in bits [12:6] and the amplitude in bits [5:0]. Bits [19:13] are zero.
- R3: A channel produces a hit word only when its amplitude is strictly greater than the threshold sampled with its trigger. An amplitude equal to the threshold is discarded.
- R4: Hit words within a packet appear in strictly ascending channel order.
- R5: A frame with no channel above threshold still yields a packet consisting of the header alone, with the last flag set on that header.
- R6: The last flag is high on the final word of each packet and low on every other word.
- R7: While valid is high and ready is low, the valid, data and last outputs hold their values.
- R8: Up to four triggers can wait behind the packet being emitted. Their packets leave in trigger order.
- R9: A trigger that arrives while the queue already holds four entries is dropped and sets the overflow flag. The flag then stays set until reset.
- R10: After reset, valid is low and the overflow flag is low.
- R11: Exactly one packet is emitted for every trigger that was not dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger strobe, one cycle per trigger |
| frame_i | input | 768 | Sample frame; channel n occupies bits [6n+5:6n] |
| thresh_i | input | 6 | Threshold applied to this trigger's frame |
| chip_addr_i | input | 8 | Chip identity written into the header |
| bx_cnt_i | input | 12 | Running bunch-crossing counter, used as timestamp |
| pkt_ready_i | input | 1 | Downstream accepts a word |
| pkt_valid_o | output | 1 | A packet word is presented |
| pkt_data_o | output | 20 | Header or hit word |
| pkt_last_o | output | 1 | Marks the final word of a packet |
| trig_ovf_o | output | 1 | Sticky flag set when a trigger was dropped |

## Verification
The assertions check the following on every cycle: the output holds during backpressure, hit channels rise within a packet, every emitted amplitude exceeds its captured threshold, and the overflow flag is set on a dropped trigger and never clears. They also check that the trigger queue never exceeds its depth and that an idle cycle follows each packet. Other behaviours can only be shown by the bench's scenarios, because they depend on the whole frame and on trigger history. These are that exactly the qualifying channels appear with the correct amplitudes, that the header carries the values sampled at the trigger, that empty and fully occupied frames yield correct lengths, and that queued triggers produce the right number of packets in the right order.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
  localparam int DEF_NUM_CH   = 128;
  localparam int DEF_AMP_W    = 6;
  localparam int DEF_CHIP_W   = 8;
  localparam int DEF_TS_W     = 12;
  localparam int DEF_Q_DEPTH  = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_HIT
  } emit_state_e;
endpackage

// File: rtl/hpb_trig_fifo.sv
module hpb_trig_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;
  logic              full, do_push, do_pop;

  assign full    = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full || do_pop);
  assign data_o  = mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovf_o    <= 1'b0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (push_i && !do_push) ovf_o <= 1'b1;
    end
  end

  // R8
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  // R9
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> ovf_o);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
endmodule

// File: rtl/hpb_hit_cmp.sv
module hpb_hit_cmp #(
  parameter int NUM_CH = 128,
  parameter int AMP_W  = 6
) (
  input  logic [NUM_CH*AMP_W-1:0] frame_i,
  input  logic [AMP_W-1:0]        thr_i,
  output logic [NUM_CH-1:0]       mask_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign mask_o[g] = frame_i[g*AMP_W +: AMP_W] > thr_i;
  end
endmodule

// File: rtl/hpb_lowest_hit.sv
module hpb_lowest_hit #(
  parameter int NUM_CH = 128,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] mask_i,
  output logic [CH_W-1:0]   idx_o,
  output logic              any_o,
  output logic              single_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = CH_W'(i);
    end
  end

  assign any_o    = |mask_i;
  assign single_o = any_o && ((mask_i & (mask_i - NUM_CH'(1))) == '0);
endmodule

// File: rtl/hit_packet_builder.sv
module hit_packet_builder
  import hpb_pkg::*;
#(
  parameter int NUM_CH  = DEF_NUM_CH,
  parameter int AMP_W   = DEF_AMP_W,
  parameter int CHIP_W  = DEF_CHIP_W,
  parameter int TS_W    = DEF_TS_W,
  parameter int Q_DEPTH = DEF_Q_DEPTH,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int FRAME_W = NUM_CH * AMP_W,
  localparam int WORD_W  = CHIP_W + TS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [AMP_W-1:0]   thresh_i,
  input  logic [CHIP_W-1:0]  chip_addr_i,
  input  logic [TS_W-1:0]    bx_cnt_i,
  input  logic               pkt_ready_i,
  output logic               pkt_valid_o,
  output logic [WORD_W-1:0]  pkt_data_o,
  output logic               pkt_last_o,
  output logic               trig_ovf_o
);
  localparam int HIT_W   = CH_W + AMP_W;
  localparam int ENTRY_W = CHIP_W + TS_W + AMP_W + FRAME_W;

  logic [ENTRY_W-1:0] head;
  logic               q_empty, pop;
  logic [CHIP_W-1:0]  head_chip;
  logic [TS_W-1:0]    head_ts;
  logic [AMP_W-1:0]   head_thr;
  logic [FRAME_W-1:0] head_frame;
  logic [NUM_CH-1:0]  load_mask;

  emit_state_e        state_q;
  logic [FRAME_W-1:0] frame_q;
  logic [NUM_CH-1:0]  mask_q;
  logic [CHIP_W-1:0]  chip_q;
  logic [TS_W-1:0]    ts_q;
  logic [AMP_W-1:0]   thr_q;

  logic [CH_W-1:0]    cur_idx;
  logic               any_hit, one_hit;
  logic [AMP_W-1:0]   cur_amp;
  logic               xfer;

  hpb_trig_fifo #(.DATA_W(ENTRY_W), .DEPTH(Q_DEPTH)) trig_q_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (trig_i),
    .data_i  ({chip_addr_i, bx_cnt_i, thresh_i, frame_i}),
    .pop_i   (pop),
    .data_o  (head),
    .empty_o (q_empty),
    .ovf_o   (trig_ovf_o)
  );

  assign {head_chip, head_ts, head_thr, head_frame} = head;

  hpb_hit_cmp #(.NUM_CH(NUM_CH), .AMP_W(AMP_W)) cmp_i (
    .frame_i (head_frame),
    .thr_i   (head_thr),
    .mask_o  (load_mask)
  );

  hpb_lowest_hit #(.NUM_CH(NUM_CH), .CH_W(CH_W)) pick_i (
    .mask_i   (mask_q),
    .idx_o    (cur_idx),
    .any_o    (any_hit),
    .single_o (one_hit)
  );

  assign pop     = (state_q == ST_IDLE) && !q_empty;
  assign cur_amp = frame_q[32'(cur_idx) * AMP_W +: AMP_W];
  assign xfer    = pkt_valid_o && pkt_ready_i;

  always_comb begin
    pkt_valid_o = 1'b0;
    pkt_last_o  = 1'b0;
    pkt_data_o  = '0;
    case (state_q)
      ST_HDR: begin
        pkt_valid_o = 1'b1;
        pkt_data_o  = {chip_q, ts_q};
        pkt_last_o  = !any_hit;
      end
      ST_HIT: begin
        pkt_valid_o = 1'b1;
        pkt_data_o  = {{(WORD_W - HIT_W){1'b0}}, cur_idx, cur_amp};
        pkt_last_o  = one_hit;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      frame_q <= '0;
      chip_q  <= '0;
      ts_q    <= '0;
      thr_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (pop) begin
          frame_q <= head_frame;
          mask_q  <= load_mask;
          chip_q  <= head_chip;
          ts_q    <= head_ts;
          thr_q   <= head_thr;
          state_q <= ST_HDR;
        end
        ST_HDR: if (xfer) state_q <= any_hit ? ST_HIT : ST_IDLE;
        ST_HIT: if (xfer) begin
          mask_q[cur_idx] <= 1'b0;
          if (one_hit) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=>
      (pkt_valid_o && $stable(pkt_data_o) && $stable(pkt_last_o)));
  // R4
  ascend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HIT && xfer && !pkt_last_o) |=>
      (pkt_data_o[HIT_W-1:AMP_W] > $past(pkt_data_o[HIT_W-1:AMP_W])));
  // R3
  above_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HIT) |-> (pkt_data_o[AMP_W-1:0] > thr_q));
  // R6
  pkt_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && pkt_last_o) |=> !pkt_valid_o);
endmodule

// File: tb/hit_packet_builder_tb_top.sv
module hit_packet_builder_tb_top;
  localparam int NUM_CH  = 128;
  localparam int AMP_W   = 6;
  localparam int FRAME_W = NUM_CH * AMP_W;
  localparam int WORD_W  = 20;
  localparam int NVEC    = 8;
  // mode: 0 pseudo-random, 1 all zero, 2 all max, 3 sparse (every 19th channel = seed)
  localparam int V_MODE [NVEC] = '{0, 0, 0, 1, 2, 2, 3, 3};
  localparam int V_SEED [NVEC] = '{5, 9, 3, 0, 0, 0, 50, 50};
  localparam int V_THR  [NVEC] = '{40, 0, 62, 0, 62, 63, 49, 50};

  logic               clk = 1'b0;
  logic               rst_ni;
  logic               trig_i;
  logic [FRAME_W-1:0] frame_i;
  logic [5:0]         thresh_i;
  logic [7:0]         chip_addr_i;
  logic [11:0]        bx_cnt_i;
  logic               pkt_ready_i;
  logic               pkt_valid_o;
  logic [WORD_W-1:0]  pkt_data_o;
  logic               pkt_last_o;
  logic               trig_ovf_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [WORD_W-1:0] exp_w [NUM_CH+1];
  int n_exp;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  hit_packet_builder dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .trig_i(trig_i), .frame_i(frame_i),
    .thresh_i(thresh_i), .chip_addr_i(chip_addr_i), .bx_cnt_i(bx_cnt_i),
    .pkt_ready_i(pkt_ready_i), .pkt_valid_o(pkt_valid_o),
    .pkt_data_o(pkt_data_o), .pkt_last_o(pkt_last_o), .trig_ovf_o(trig_ovf_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <100000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [FRAME_W-1:0] mk_frame(input int mode, input int seed);
    logic [FRAME_W-1:0] f = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      int v;
      case (mode)
        0: v = (ch * 37 + seed * 11 + (ch / 8) * seed) % 64;
        2: v = 63;
        3: v = (ch % 19 == 0) ? seed % 64 : 0;
        default: v = 0;
      endcase
      f[ch*AMP_W +: AMP_W] = 6'(v);
    end
    return f;
  endfunction

  task automatic build_exp(input logic [FRAME_W-1:0] f, input logic [5:0] thr,
                           input logic [7:0] chip, input logic [11:0] ts);
    exp_w[0] = {chip, ts};
    n_exp = 1;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (f[ch*AMP_W +: AMP_W] > thr) begin
        exp_w[n_exp] = {7'b0, 7'(ch), f[ch*AMP_W +: AMP_W]};
        n_exp++;
      end
    end
  endtask

  task automatic send_trig(input logic [FRAME_W-1:0] f, input logic [5:0] thr,
                           input logic [7:0] chip, input logic [11:0] ts);
    @(negedge clk);
    frame_i = f; thresh_i = thr; chip_addr_i = chip; bx_cnt_i = ts; trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    frame_i = ~f; thresh_i = thr ^ 6'h15; chip_addr_i = ~chip; bx_cnt_i = ts + 12'd77;
  endtask

  // Collects one packet; random_rdy toggles ready to exercise backpressure.
  task automatic collect(input bit random_rdy);
    int idx = 0;
    int cyc = 0;
    bit hold = 0;
    logic [WORD_W-1:0] hold_d = '0;
    logic hold_l = 0;
    while (idx < n_exp && cyc < 5000) begin
      logic r;
      @(negedge clk);
      cyc++;
      if (hold) begin
        chk(pkt_valid_o && pkt_data_o == hold_d && pkt_last_o == hold_l,
            "R7", "stall hold", 32'(pkt_data_o), 32'(hold_d));
        hold = 0;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = random_rdy ? lfsr[0] : 1'b1;
      pkt_ready_i = r;
      if (pkt_valid_o) begin
        if (r) begin
          if (idx == 0)
            chk(pkt_data_o == exp_w[0], "R1", "header", 32'(pkt_data_o), 32'(exp_w[0]));
          else
            chk(pkt_data_o == exp_w[idx], "R2 R3 R4", "hit word",
                32'(pkt_data_o), 32'(exp_w[idx]));
          chk(pkt_last_o == (idx == n_exp - 1), (n_exp == 1) ? "R5" : "R6",
              "last flag", 32'(pkt_last_o), 32'(idx == n_exp - 1));
          idx++;
        end else begin
          hold = 1; hold_d = pkt_data_o; hold_l = pkt_last_o;
        end
      end
    end
    chk(idx == n_exp, "R11", "packet word count", 32'(idx), 32'(n_exp));
  endtask

  initial begin
    rst_ni = 1'b0; trig_i = 1'b0; frame_i = '0; thresh_i = '0;
    chip_addr_i = '0; bx_cnt_i = '0; pkt_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!pkt_valid_o, "R10", "valid in reset", 32'(pkt_valid_o), 0);
    chk(!trig_ovf_o, "R10", "ovf in reset", 32'(trig_ovf_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!pkt_valid_o, "R10", "valid after reset", 32'(pkt_valid_o), 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [FRAME_W-1:0] f = mk_frame(V_MODE[i], V_SEED[i]);
      logic [7:0]  chip = 8'hA0 + 8'(i);
      logic [11:0] ts = 12'h105 * 12'(i + 1);
      build_exp(f, 6'(V_THR[i]), chip, ts);
      send_trig(f, 6'(V_THR[i]), chip, ts);
      collect(i % 2 == 1);
      @(negedge clk);
      pkt_ready_i = 1'b0;
    end
    chk(!trig_ovf_o, "R9", "no overflow without excess", 32'(trig_ovf_o), 0);

    // R8 R9 R11: seven back-to-back triggers with ready low; five fit.
    pkt_ready_i = 1'b0;
    @(negedge clk);
    frame_i = '0; thresh_i = '0; chip_addr_i = 8'h5C;
    for (int k = 0; k < 7; k++) begin
      trig_i = 1'b1; bx_cnt_i = 12'h700 + 12'(k);
      @(negedge clk);
    end
    trig_i = 1'b0;
    chk(trig_ovf_o, "R9", "overflow set on drop", 32'(trig_ovf_o), 1);
    for (int k = 0; k < 5; k++) begin
      build_exp('0, '0, 8'h5C, 12'h700 + 12'(k));
      collect(k % 2 == 0);
      chk(1'b1, "R8", "queued packet in order", 0, 0);
    end
    @(negedge clk);
    pkt_ready_i = 1'b1;
    repeat (20) @(negedge clk);
    chk(!pkt_valid_o, "R11", "no packet for dropped trigger", 32'(pkt_valid_o), 0);
    chk(trig_ovf_o, "R9", "overflow sticky", 32'(trig_ovf_o), 1);

    build_exp(mk_frame(3, 50), 6'd49, 8'h11, 12'hABC);
    send_trig(mk_frame(3, 50), 6'd49, 8'h11, 12'hABC);
    collect(1'b0);
    @(negedge clk);
    chk(trig_ovf_o, "R9", "overflow sticky after packet", 32'(trig_ovf_o), 1);

    rst_ni = 1'b0;
    @(negedge clk);
    chk(!trig_ovf_o, "R10", "overflow cleared by reset", 32'(trig_ovf_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule